// File: doc/BRIEF.md
# Sv32 Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table in memory. Each request carries the virtual address, the kind of access (load, store or instruction fetch), the effective privilege (supervisor or user), the supervisor-user-memory permit bit and the translation control word. When the control word selects no translation, the address goes straight through. Otherwise the walker reads one or two page table entries through a single-outstanding read port. It then reports either the physical address or a page fault.

A leaf may sit at either level. A leaf at the first level maps a 4 MiB megapage, and its low physical page number is taken from the virtual address. Permissions are checked on the leaf: read, write and execute grants, user-page access and the permit bit for supervisor access. A supervisor may never fetch from a user page. The walker holds one request at a time and accepts a new one only when it is idle.

Top module: `sv32_walker`

## Requirements
- R1: After reset, `done` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: When `req_satp[31]` is 0, no memory read is made. `done` rises in the cycle after the request is accepted, with `done_pa = {2'b00, req_va}` and `done_fault = 0`, whatever the access and privilege.
- R3: When `req_satp[31]` is 1, the first read address is `{req_satp[21:0], va[31:22], 2'b00}`. If that entry is a valid pointer, the second read address is `{pte[31:10], va[21:12], 2'b00}`.
- R4: PTE bits are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, PPN[0]=bits 19:10 and PPN[1]=bits 31:20. An entry with R or X set is a leaf. A level-0 leaf gives `done_pa = {pte[31:10], va[11:0]}`.
- R5: A level-1 leaf gives `done_pa = {pte[31:20], va[21:0]}`. A level-1 leaf with a nonzero PPN[0] field faults.
- R6: An entry with V=0, or with W=1 and R=0, faults at either level, and no further read follows it. A non-leaf entry at level 0 faults.
- R7: The access code is 0 for load, 1 for store and 2 for fetch. A load needs R, a store needs W and a fetch needs X on the leaf, otherwise the walk faults.
- R8: A user access (`req_priv_s` = 0) to a leaf with U=0 faults.
- R9: A supervisor load or store to a U=1 leaf is allowed only when `req_sum` is 1. A supervisor fetch from a U=1 leaf always faults.
- R10: `mem_req_valid` stays high with a stable address until `mem_req_ready`. No new read is issued before the response to the previous one arrives.
- R11: `done` is a one-cycle pulse, raised in the cycle after the final response. `done_cause` gives the access code of the request, and `done_pa` is 0 when `done_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted at this edge |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch |
| req_priv_s | input | 1 | 1 supervisor, 0 user |
| req_sum | input | 1 | Supervisor may touch user pages |
| req_satp | input | 32 | Bit 31 enables translation, bits 21:0 root page number |
| mem_req_valid | output | 1 | PTE read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Physical address of the PTE |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | PTE value |
| done | output | 1 | Result pulse |
| done_pa | output | 34 | Physical address result |
| done_fault | output | 1 | Page fault |
| done_cause | output | 2 | Access code of the finished request |

## Verification
The Sv32 entry format is fixed, so the bench builds the walker with its package constants. These are 32-bit virtual and 34-bit physical addresses, 10-bit page number indices and a 12-bit offset. With these values both walk depths, megapage forming and every permission combination of the five low PTE bits can be reached. The random memory handshake delays also exercise the hold rule on the read port.

// File: rtl/sv32_pkg.sv
package sv32_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 34;
  localparam int PTE_W  = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = 10;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PPN1_W = PPN_W - VPN_W;
  localparam int MODE_BIT = VA_W - 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic [PPN1_W-1:0] ppn1;
    logic [VPN_W-1:0]  ppn0;
    logic [1:0]        rsw;
    logic              d, a, g, u, x, w, r, v;
  } pte_t;

  function automatic logic pte_is_leaf(pte_t p);
    return p.r | p.x;
  endfunction

  function automatic logic [PA_W-1:0] pte_addr(logic [PPN_W-1:0] ppn,
                                               logic [VPN_W-1:0] vpn);
    return {ppn, vpn, 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] leaf_pa(pte_t p, logic lvl1,
                                              logic [VA_W-1:0] va);
    return lvl1 ? {p.ppn1, va[VPN_W+OFF_W-1:0]}
                : {p.ppn1, p.ppn0, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/sv32_pte_eval.sv
module sv32_pte_eval
  import sv32_pkg::*;
(
  input  pte_t            pte,
  input  logic            lvl1,
  input  logic [1:0]      acc,
  input  logic            priv_s,
  input  logic            sum,
  input  logic [VA_W-1:0] va,
  output logic            leaf,
  output logic            fault,
  output logic [PA_W-1:0] pa
);
  logic bad_fmt, deep_ptr, misalign, perm_ok, priv_ok;
  logic unused_pte_bits;

  assign unused_pte_bits = ^{pte.rsw, pte.d, pte.a, pte.g};

  always_comb begin
    leaf     = pte_is_leaf(pte);
    bad_fmt  = !pte.v || (pte.w && !pte.r);
    deep_ptr = !leaf && !lvl1;
    misalign = leaf && lvl1 && (pte.ppn0 != '0);
    case (acc)
      ACC_STORE: perm_ok = pte.w;
      ACC_FETCH: perm_ok = pte.x;
      default:   perm_ok = pte.r;
    endcase
    if (!priv_s)    priv_ok = pte.u;
    else if (pte.u) priv_ok = (acc != ACC_FETCH) && sum;
    else            priv_ok = 1'b1;
    fault = bad_fmt || deep_ptr || (leaf && (misalign || !perm_ok || !priv_ok));
    pa    = leaf_pa(pte, lvl1, va);
  end
endmodule

// File: rtl/sv32_addr_gen.sv
module sv32_addr_gen
  import sv32_pkg::*;
(
  input  logic             lvl1,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic [PPN_W-1:0] next_ppn,
  input  logic [VPN_W-1:0] vpn1,
  input  logic [VPN_W-1:0] vpn0,
  output logic [PA_W-1:0]  addr
);
  always_comb addr = lvl1 ? pte_addr(root_ppn, vpn1) : pte_addr(next_ppn, vpn0);
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic             req_priv_s,
  input  logic             req_sum,
  input  logic [VA_W-1:0]  req_satp,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  done_pa,
  output logic             done_fault,
  output logic [1:0]       done_cause
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             priv_q, sum_q, lvl1_q;
  logic [PPN_W-1:0] root_q, next_q;
  logic             done_q, fault_q;
  logic [PA_W-1:0]  pa_q;
  logic             unused_satp;

  // named internal events, watched by the checker
  logic             ev_rsp;
  logic             ev_leaf, ev_fault;
  logic [PA_W-1:0]  ev_pa;
  pte_t             ev_pte;

  assign unused_satp = ^req_satp[MODE_BIT-1:PPN_W];
  assign ev_pte      = pte_t'(mem_rsp_data);
  assign ev_rsp      = (st == ST_WAIT) && mem_rsp_valid;

  sv32_pte_eval u_eval (
    .pte(ev_pte), .lvl1(lvl1_q), .acc(acc_q), .priv_s(priv_q), .sum(sum_q),
    .va(va_q), .leaf(ev_leaf), .fault(ev_fault), .pa(ev_pa)
  );

  sv32_addr_gen u_addr (
    .lvl1(lvl1_q), .root_ppn(root_q), .next_ppn(next_q),
    .vpn1(va_q[VA_W-1:VA_W-VPN_W]), .vpn0(va_q[OFF_W+VPN_W-1:OFF_W]),
    .addr(mem_req_addr)
  );

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign done          = done_q;
  assign done_pa       = pa_q;
  assign done_fault    = fault_q;
  assign done_cause    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      priv_q  <= 1'b0;
      sum_q   <= 1'b0;
      lvl1_q  <= 1'b1;
      root_q  <= '0;
      next_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          acc_q  <= req_acc;
          priv_q <= req_priv_s;
          sum_q  <= req_sum;
          root_q <= req_satp[PPN_W-1:0];
          lvl1_q <= 1'b1;
          if (!req_satp[MODE_BIT]) begin
            done_q  <= 1'b1;
            fault_q <= 1'b0;
            pa_q    <= {{(PA_W-VA_W){1'b0}}, req_va};
          end else begin
            st <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (ev_fault || ev_leaf) begin
            st      <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= ev_fault;
            pa_q    <= ev_fault ? '0 : ev_pa;
          end else begin
            next_q <= {ev_pte.ppn1, ev_pte.ppn0};
            lvl1_q <= 1'b0;
            st     <= ST_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk
  import sv32_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            req_mode,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            done,
  input logic [PA_W-1:0] done_pa,
  input logic            done_fault,
  input logic            ev_rsp,
  input logic [4:0]      ev_flags,
  input logic            ctx_priv_s,
  input logic [1:0]      ctx_acc
);
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_BARE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_mode |=>
      done && !done_fault && done_pa == {2'b00, $past(req_va)}); // R2
  AST_SFETCH_UPAGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp && ctx_priv_s && ctx_acc == 2'd2 && ev_flags[4] && (ev_flags[1] || ev_flags[3])
      |=> done && done_fault); // R9
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp && ev_flags[2] && !ev_flags[1] |=> done && done_fault); // R6
endmodule

bind sv32_walker sv32_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_mode(req_satp[31]), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .done(done), .done_pa(done_pa),
  .done_fault(done_fault), .ev_rsp(ev_rsp), .ev_flags(mem_rsp_data[4:0]),
  .ctx_priv_s(priv_q), .ctx_acc(acc_q)
);

// File: tb/sim_sv32_walker.sv
module sim_sv32_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FV = 32'h1, FR = 32'h2, FW = 32'h4, FX = 32'h8, FU = 32'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_priv_s = 0, req_sum = 0;
  logic [31:0] req_va = 0, req_satp = 0;
  logic [1:0]  req_acc = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_rsp_data = 0;
  logic done, done_fault;
  logic [33:0] done_pa;
  logic [1:0]  done_cause;

  int checks = 0, errors = 0, nreads = 0;
  logic [31:0] cur_va, cur_satp, cur_p1, cur_p0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sv32_walker u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model with random handshake delays
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_req_ready = 1;
        if (nreads == 0)
          chk("R3 first read address", mem_req_addr, {cur_satp[21:0], cur_va[31:22], 2'b00});
        else if (nreads == 1)
          chk("R3 second read address", mem_req_addr, {cur_p1[31:10], cur_va[21:12], 2'b00});
        else
          chk("R10 read count", nreads, 2);
        mem_rsp_data = (nreads == 0) ? cur_p1 : cur_p0;
        nreads++;
        @(negedge clk);
        mem_req_ready = 0;
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk("R10 no read while outstanding", mem_req_valid, 0);
        end
        mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  function automatic void model(input logic [31:0] va, input logic [1:0] acc,
      input logic ps, input logic sum, input logic [31:0] satp, input logic [31:0] p1,
      input logic [31:0] p0, output logic f, output logic [33:0] pa, output int nr);
    logic [31:0] p; logic mega, ok;
    f = 0; pa = {2'b00, va}; nr = 0;
    if (!satp[31]) return;
    p = p1; nr = 1; mega = 1;
    if (!p[0] || (p[2] && !p[1])) begin f = 1; pa = 0; return; end
    if (!(p[1] || p[3])) begin
      p = p0; nr = 2; mega = 0;
      if (!p[0] || (p[2] && !p[1]) || !(p[1] || p[3])) begin f = 1; pa = 0; return; end
    end
    ok = (acc == 2'd1) ? p[2] : (acc == 2'd2) ? p[3] : p[1];
    if (!ps && !p[4]) ok = 0;
    if (ps && p[4] && (acc == 2'd2 || !sum)) ok = 0;
    if (mega && p[19:10] != 0) ok = 0;
    f = !ok;
    pa = f ? 34'h0 : mega ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
  endfunction

  task automatic run(string tag, logic [31:0] va, logic [1:0] acc, logic ps, logic sum,
                     logic [31:0] satp, logic [31:0] p1, logic [31:0] p0);
    logic ef; logic [33:0] epa; int enr; int n;
    model(va, acc, ps, sum, satp, p1, p0, ef, epa, enr);
    @(negedge clk);
    cur_va = va; cur_satp = satp; cur_p1 = p1; cur_p0 = p0; nreads = 0;
    req_va = va; req_acc = acc; req_priv_s = ps; req_sum = sum; req_satp = satp;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk({tag, " R11 done seen"}, done, 1);
    chk({tag, " fault"}, done_fault, ef);
    chk({tag, " pa"}, done_pa, epa);
    chk({tag, " R11 cause"}, done_cause, acc);
    chk({tag, " read count"}, nreads, enr);
    @(negedge clk);
    chk({tag, " R11 pulse width"}, done, 0);
  endtask

  function automatic logic [31:0] rnd_ptr();
    return {$urandom} & 32'hFFFF_FC00 | FV | (($urandom % 10 == 0) ? 32'h0 : 32'h0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, p1, p0;
    void'($urandom(32'd20220414));
    repeat (2) @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 mem_req_valid after reset", mem_req_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    rst_n = 1;
    s = 32'h8000_0123;
    // R2 bare: pass-through regardless of access
    run("R2 bare fetch user", 32'hDEAD_BEEF, 2'd2, 0, 0, 32'h0000_0123, 0, 0);
    // R4 level-0 leaf
    run("R4 4K leaf load", 32'h1234_5678, 2'd0, 1, 0, s, 32'h0004_5601, 32'hABCD_E003);
    // R5 megapage and misaligned megapage
    run("R5 megapage", 32'h1234_5678, 2'd1, 1, 0, s, 32'hFED0_0007, 0);
    run("R5 misaligned megapage", 32'h1234_5678, 2'd0, 1, 0, s, 32'hFED0_0403, 0);
    // R6 format faults
    run("R6 V=0 level1", 32'h0040_1000, 2'd0, 1, 0, s, 32'h1234_5400, 0);
    run("R6 W without R", 32'h0040_1000, 2'd1, 1, 0, s, 32'h1234_5405, 0);
    run("R6 pointer at level0", 32'h0040_1000, 2'd0, 1, 0, s, 32'h0000_0401, 32'h0000_0801);
    // R7 permissions
    run("R7 store to RO", 32'h0040_1000, 2'd1, 1, 0, s, 32'h0000_0401, 32'h0000_0803);
    run("R7 fetch no X", 32'h0040_1000, 2'd2, 1, 0, s, 32'h0000_0401, 32'h0000_0807);
    // R8 user on supervisor page
    run("R8 user U=0", 32'h0040_1000, 2'd0, 0, 0, s, 32'h0000_0401, 32'h0000_0803);
    run("R8 user U=1", 32'h0040_1000, 2'd0, 0, 0, s, 32'h0000_0401, 32'h0000_0813);
    // R9 supervisor on user page
    run("R9 S load U sum0", 32'h0040_1000, 2'd0, 1, 0, s, 32'h0000_0401, 32'h0000_0813);
    run("R9 S load U sum1", 32'h0040_1000, 2'd0, 1, 1, s, 32'h0000_0401, 32'h0000_0813);
    run("R9 S fetch U sum1", 32'h0040_1000, 2'd2, 1, 1, s, 32'h0000_0401, 32'h0000_081B);
    // random mix: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 10;
      if (k < 6) p1 = rnd_ptr();
      else if (k < 9) p1 = ({$urandom} & 32'hFFF0_0000) | FV | ({$urandom} & (FR|FW|FX|FU))
                           | (($urandom % 8 == 0) ? 32'h0000_0400 : 32'h0);
      else p1 = $urandom;
      if ($urandom % 8 == 0) p1 = p1 & ~FV;
      p0 = ({$urandom} & 32'hFFFF_FC1E) | (($urandom % 8 == 0) ? 32'h0 : FV);
      run("R3/R4/R5/R6/R7/R8/R9 random", $urandom, 2'($urandom % 3), 1'($urandom),
          1'($urandom), (($urandom % 10 == 0) ? 32'h0 : 32'h8000_0000) | ({$urandom} & 32'h003F_FFFF),
          p1, p0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule